// File: doc/BRIEF.md
# Local Bus Burst Master Sequencer

This block is the master side of a synchronous 32-bit local bus with active-low control strobes. A request carries a longword start address, a direction and a longword count. The block turns it into one or more bus accesses. Each access opens with a single address-strobe cycle. One or more data phases follow, and the final phase of the access is flagged with the burst-last strobe. The block also drives the transceiver enable and direction outputs that steer external data buffers.

Two burst modes exist. With the terminate input disabled, an access carries at most four longwords and never crosses an aligned 16-byte boundary, so address bits 3:2 count upward without wrapping inside one access. With the terminate input enabled, the burst runs on until the slave asserts terminate. A new address cycle then resumes at the next longword. In both modes each data phase lasts a programmable number of wait cycles, and the slave can cut it short with its active-low ready input.

Requests are accepted with a valid/ready handshake, and `req_ready` is high only while the block is idle. Write data enters as a valid/ready stream. The word on `wr_data` is driven onto the bus during a write phase. The phase cannot complete while `wr_valid` is low, and `wr_ready` marks the cycle in which the word is consumed. Read data leaves through a holding register flagged by a one-cycle `rd_valid`. It has no back-pressure, so the consumer must take each word in that cycle. `cfg_wait` and `cfg_term_en` must stay stable while a request is in progress, and `req_count` must be at least one.

Top module: `lbus_burst_master`

## Requirements
- R1: `lb_ads_n` is low for exactly one clock at the start of each access, with the access's first longword address on `lb_addr`. The first data phase begins in the next clock.
- R2: `lb_blast_n` is low during every clock of the final data phase of each access, and high otherwise.
- R3: `lb_wr` is high for a write request and low for a read request, and it holds that level for the whole request.
- R4: `lb_addr` carries address bits 31:2. Each completed data phase advances it by one longword, so bits 3:2 step upward through a burst.
- R5: With `cfg_terminate_en` low, an access carries at most four longwords and never crosses a 16-byte boundary (longword address bits 1:0 of the following phase never return to 0 inside one access). The next address cycle follows in the clock after the access's last phase, and `lb_bterm_n` has no effect.
- R6: With `cfg_terminate_en` high, a burst continues across 16-byte boundaries. A data phase completed with `lb_bterm_n` sampled low ends the access, and the next clock is an address cycle at the following longword if data remains.
- R7: `lb_den_n` is low exactly in data-phase clocks. `lb_rx_n` is low throughout a read request, both in its address and its data clocks, and high during writes and idle.
- R8: A data phase completes at the first rising edge at which `cfg_wait` further cycles have elapsed (the phase lasts `cfg_wait`+1 clocks), or `lb_ready_n` is low, or `lb_bterm_n` is low while terminate is enabled.
- R9: During a write phase, `lb_dout` carries `wr_data` and `lb_doe` is high. The phase does not complete while `wr_valid` is low, and `wr_ready` is high in exactly the clock in which the phase completes.
- R10: After the last longword of a request, all strobes return high. `done` pulses for one clock in the clock after the final phase, and `req_ready` is high in that clock.
- R11: Each completed read phase captures `lb_din`. In the next clock, `rd_valid` is high for one cycle and `rd_data` holds the captured word.
- R12: After reset, `lb_ads_n`, `lb_blast_n`, `lb_den_n` and `lb_rx_n` are high, `done` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | WS_W | Wait cycles added to each data phase |
| cfg_terminate_en | input | 1 | Enables the burst-terminate input and lifts the four-longword cap |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (high while idle) |
| req_addr | input | 30 | Start longword address, bits 31:2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_count | input | CNT_W | Number of longwords, at least 1 |
| wr_valid | input | 1 | Write data word valid |
| wr_ready | output | 1 | Write data word consumed this cycle |
| wr_data | input | DATA_W | Write data word |
| rd_valid | output | 1 | Read data word valid (one cycle) |
| rd_data | output | DATA_W | Read holding register |
| done | output | 1 | One-cycle pulse after the last longword |
| lb_ads_n | output | 1 | Address strobe, active low |
| lb_blast_n | output | 1 | Burst-last strobe, active low |
| lb_wr | output | 1 | Write/read line, high for writes |
| lb_addr | output | 30 | Bus address bits 31:2 |
| lb_dout | output | DATA_W | Bus write data |
| lb_doe | output | 1 | Bus data output enable |
| lb_din | input | DATA_W | Bus read data |
| lb_ready_n | input | 1 | Slave ready, active low |
| lb_bterm_n | input | 1 | Burst terminate, active low |
| lb_den_n | output | 1 | Transceiver enable, active low |
| lb_rx_n | output | 1 | Transceiver direction, low while receiving |

## Verification
The bench builds the block with `CNT_W` = 5 and `WS_W` = 3. That allows requests of up to 31 longwords, enough to cross several 16-byte boundaries in one request, and wait settings up to 7, enough for a ready input to visibly cut a phase short. Requests start both on and off 16-byte boundaries. Terminate is exercised enabled and disabled with the terminate input pulsed, and one write has a stalled data stream. The bench's own slave model predicts each phase's completion and each access boundary.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } lbm_state_e;
endpackage

// File: rtl/lbm_wait_timer.sv
module lbm_wait_timer #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  output logic            expired
);
  logic [WS_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R8
endmodule

// File: rtl/lbm_burst_edge.sv
module lbm_burst_edge #(
  parameter int CNT_W      = 6,
  parameter int BURST_LOG2 = 2
) (
  input  logic                  term_en,
  input  logic [CNT_W-1:0]      remaining,
  input  logic [BURST_LOG2-1:0] addr_lo,
  output logic                  last_beat
);
  logic final_lw;
  logic at_boundary;

  assign final_lw    = (remaining == CNT_W'(1));
  assign at_boundary = &addr_lo;

  always_comb begin
    if (term_en) last_beat = final_lw;
    else         last_beat = final_lw || at_boundary;
  end
endmodule

// File: rtl/lbm_rd_hold.sv
module lbm_rd_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= din;
    end
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (rd_valid && rd_data == $past(din))); // R11
endmodule

// File: rtl/lbus_burst_master.sv
module lbus_burst_master #(
  parameter int CNT_W      = 6,
  parameter int WS_W       = 4,
  parameter int DATA_W     = 32,
  parameter int BURST_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WS_W-1:0]   cfg_wait,
  input  logic              cfg_terminate_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:2]       req_addr,
  input  logic              req_write,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              lb_ads_n,
  output logic              lb_blast_n,
  output logic              lb_wr,
  output logic [31:2]       lb_addr,
  output logic [DATA_W-1:0] lb_dout,
  output logic              lb_doe,
  input  logic [DATA_W-1:0] lb_din,
  input  logic              lb_ready_n,
  input  logic              lb_bterm_n,
  output logic              lb_den_n,
  output logic              lb_rx_n
);
  import lbm_pkg::*;

  localparam int LO_HI = BURST_LOG2 + 1;

  lbm_state_e        st;
  logic [31:2]       cur_addr;
  logic [CNT_W-1:0]  remaining;
  logic              is_wr;
  logic              done_q;
  logic              in_data;
  logic              term_hit;
  logic              wr_ok;
  logic              tmr_expired;
  logic              tmr_load;
  logic              beat_done;
  logic              final_beat;
  logic              acc_last;

  assign in_data    = (st == ST_DATA);
  assign term_hit   = cfg_terminate_en && !lb_bterm_n;
  assign wr_ok      = !is_wr || wr_valid;
  assign beat_done  = in_data && wr_ok && (tmr_expired || !lb_ready_n || term_hit);
  assign final_beat = (remaining == CNT_W'(1));
  assign tmr_load   = (st == ST_ADDR) || beat_done;

  lbm_wait_timer #(.WS_W(WS_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (cfg_wait),
    .expired  (tmr_expired)
  );

  lbm_burst_edge #(.CNT_W(CNT_W), .BURST_LOG2(BURST_LOG2)) u_edge (
    .term_en   (cfg_terminate_en),
    .remaining (remaining),
    .addr_lo   (cur_addr[LO_HI:2]),
    .last_beat (acc_last)
  );

  lbm_rd_hold #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (beat_done && !is_wr),
    .din      (lb_din),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_addr  <= '0;
      remaining <= '0;
      is_wr     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= beat_done && final_beat;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr  <= req_addr;
            is_wr     <= req_write;
            remaining <= req_count;
            st        <= ST_ADDR;
          end
        end
        ST_ADDR: st <= ST_DATA;
        ST_DATA: begin
          if (beat_done) begin
            cur_addr  <= cur_addr + 30'd1;
            remaining <= remaining - 1'b1;
            if (final_beat)                st <= ST_IDLE;
            else if (acc_last || term_hit) st <= ST_ADDR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign done       = done_q;
  assign lb_ads_n   = !(st == ST_ADDR);
  assign lb_blast_n = !(in_data && acc_last);
  assign lb_wr      = is_wr;
  assign lb_addr    = cur_addr;
  assign lb_dout    = wr_data;
  assign lb_doe     = in_data && is_wr;
  assign lb_den_n   = !in_data;
  assign lb_rx_n    = !((st != ST_IDLE) && !is_wr);
  assign wr_ready   = beat_done && is_wr;

  AST_ADS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_ads_n |=> (lb_ads_n && !lb_den_n)); // R1
  AST_BLAST_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_blast_n |-> !lb_den_n); // R2
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(lb_wr)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_den_n && $past(!lb_den_n) && !cfg_terminate_en && lb_addr != $past(lb_addr))
      |-> (lb_addr[LO_HI:2] != '0)); // R5
  AST_RX_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_rx_n |-> (!lb_wr && !req_ready)); // R7
  AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_den_n && lb_wr && !wr_valid) |=> $stable(lb_addr)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && lb_ads_n && lb_den_n && lb_blast_n)); // R10
endmodule

// File: tb/test_lbus_burst_master.sv
module test_lbus_burst_master;
  localparam int CNT_W = 5;
  localparam int WS_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WS_W-1:0] cfg_wait = '0;
  logic cfg_terminate_en = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:2] req_addr = '0;
  logic req_write = 1'b0;
  logic [CNT_W-1:0] req_count = '0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [31:0] wr_data = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic done;
  logic lb_ads_n, lb_blast_n, lb_wr, lb_doe, lb_den_n, lb_rx_n;
  logic [31:2] lb_addr;
  logic [31:0] lb_dout;
  logic [31:0] lb_din = '0;
  logic lb_ready_n = 1'b1;
  logic lb_bterm_n = 1'b1;

  int n_cmp = 0;
  int n_mis = 0;

  always #5 clk = ~clk;

  lbus_burst_master #(.CNT_W(CNT_W), .WS_W(WS_W)) i_lbus_burst_master (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_terminate_en(cfg_terminate_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_count(req_count),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .lb_ads_n(lb_ads_n), .lb_blast_n(lb_blast_n), .lb_wr(lb_wr), .lb_addr(lb_addr),
    .lb_dout(lb_dout), .lb_doe(lb_doe), .lb_din(lb_din), .lb_ready_n(lb_ready_n),
    .lb_bterm_n(lb_bterm_n), .lb_den_n(lb_den_n), .lb_rx_n(lb_rx_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int b, input bit wr);
    return wr ? (32'hA500_0000 + 32'(b) * 32'h0001_0101) : (32'h5A00_0000 ^ (32'(b) * 32'h0011_0003));
  endfunction

  // Runs one request against a bench slave model.
  // rdy_beat: beat answered with ready low; term_beat: beat answered with terminate low;
  // gap_beat: write beat whose data stream is held invalid for its first three cycles.
  task automatic do_xfer(input int a, input int n, input bit wr, input int ws, input bit ten,
                         input int rdy_beat, input int term_beat, input int gap_beat,
                         input int exp_ads);
    int beat = 0;
    int dcyc = 0;
    int gcnt = 0;
    int n_ads = 0;
    bit exp_ads_next = 1'b1;
    bit rd_pend = 1'b0;
    logic [31:0] rd_exp = '0;
    bit fin = 1'b0;
    cfg_wait = WS_W'(ws);
    cfg_terminate_en = ten;
    @(negedge clk);
    req_addr = 30'(a); req_write = wr; req_count = CNT_W'(n); req_valid = 1'b1;
    for (int cyc = 0; cyc < 2000 && !fin; cyc++) begin
      @(negedge clk);
      req_valid = 1'b0;
      // read-capture check (R11)
      if (rd_pend) chk(rd_valid && rd_data == rd_exp, "R11 rd_data", rd_data, rd_exp);
      else if (!wr) chk(!rd_valid, "R11 rd_valid idle", rd_valid, 0);
      rd_pend = 1'b0;
      if (done) begin
        chk(beat == n, "R10 beats before done", beat, n);
        chk(req_ready && lb_ads_n && lb_den_n && lb_blast_n && lb_rx_n, "R10 idle strobes",
            {req_ready, lb_ads_n, lb_den_n, lb_blast_n, lb_rx_n}, 5'h1f);
        chk(n_ads == exp_ads, "R5/R6 address cycles", n_ads, exp_ads);
        fin = 1'b1;
      end else begin
        chk(lb_wr == wr, "R3 write/read line", lb_wr, wr);
        chk(lb_rx_n == wr, "R7 direction", lb_rx_n, wr);
        if (exp_ads_next) begin
          chk(!lb_ads_n && lb_den_n && lb_addr == 30'(a + beat), "R1 address cycle",
              {lb_ads_n, lb_den_n, lb_addr}, {2'b01, 30'(a + beat)});
          n_ads++;
          exp_ads_next = 1'b0;
        end else begin
          bit last_exp;
          bit term;
          bit rdy;
          bit wv;
          bit comp;
          chk(lb_ads_n && !lb_den_n, "R7 data phase strobes", {lb_ads_n, lb_den_n}, 2'b10);
          chk(lb_addr == 30'(a + beat), "R4 address", lb_addr, 30'(a + beat));
          last_exp = (beat == n - 1) || (!ten && (((a + beat) & 3) == 3));
          chk(lb_blast_n == !last_exp, "R2 burst-last", lb_blast_n, !last_exp);
          term = (beat == term_beat);
          rdy  = (beat == rdy_beat);
          wv   = !(beat == gap_beat && gcnt < 3);
          lb_ready_n = !rdy;
          lb_bterm_n = !term;
          wr_valid = wr ? wv : 1'b0;
          wr_data  = pat(beat, 1'b1);
          lb_din   = pat(beat, 1'b0);
          comp = (!wr || wv) && ((dcyc >= ws) || rdy || (ten && term));
          #1;
          if (wr) begin
            chk(lb_doe && lb_dout == pat(beat, 1'b1), "R9 bus write data", lb_dout, pat(beat, 1'b1));
            chk(wr_ready == comp, "R9 wr_ready", wr_ready, comp);
          end
          if (beat == gap_beat) gcnt++;
          if (comp) begin
            if (!wr) begin rd_pend = 1'b1; rd_exp = pat(beat, 1'b0); end
            if ((last_exp || (ten && term)) && beat != n - 1) exp_ads_next = 1'b1;
            beat++;
            dcyc = 0;
          end else begin
            dcyc++;
          end
        end
      end
    end
    chk(fin, "R10 request finished", fin, 1);
    lb_ready_n = 1'b1; lb_bterm_n = 1'b1; wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(lb_ads_n && lb_blast_n && lb_den_n && lb_rx_n, "R12 strobes after reset",
        {lb_ads_n, lb_blast_n, lb_den_n, lb_rx_n}, 4'hf);
    chk(!done && !rd_valid && req_ready, "R12 handshake after reset",
        {done, rd_valid, req_ready}, 3'b001);
  endtask

  // R1 R2 R4: aligned four-longword write, no waits, one access
  task automatic t_write_aligned();
    do_xfer(32'h40, 4, 1'b1, 0, 1'b0, -1, -1, -1, 1);
  endtask

  // R5 R8: unaligned ten-longword read with waits splits at 16-byte boundaries
  task automatic t_read_split();
    do_xfer(32'h102, 10, 1'b0, 2, 1'b0, -1, -1, -1, 3);
  endtask

  // R8 and R5 terminate ignored: ready cuts the wait short, terminate pulse has no effect
  task automatic t_ready_early();
    do_xfer(32'h200, 4, 1'b0, 5, 1'b0, 1, 2, -1, 1);
  endtask

  // R6: terminate enabled, long write split once by terminate
  task automatic t_term_split();
    do_xfer(32'h300, 9, 1'b1, 1, 1'b1, -1, 2, -1, 2);
  endtask

  // R6: terminate enabled with no terminate, read runs across boundary in one access
  task automatic t_term_long();
    do_xfer(32'h81, 6, 1'b0, 0, 1'b1, -1, -1, -1, 1);
  endtask

  // R9: write stream stalls for three cycles on beat 1
  task automatic t_write_stall();
    do_xfer(32'h20, 3, 1'b1, 0, 1'b0, -1, -1, 1, 1);
  endtask

  // R2 R10: single longword at the top of a 16-byte block, then one at its start
  task automatic t_single();
    do_xfer(32'h13, 1, 1'b0, 1, 1'b0, -1, -1, -1, 1);
    do_xfer(32'h14, 2, 1'b1, 0, 1'b0, 0, -1, -1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_write_aligned();
    t_read_split();
    t_ready_early();
    t_term_split();
    t_term_long();
    t_write_stall();
    t_single();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule